// File: doc/BRIEF.md
# Shared Backplane Bus Master

This block is the only master on a shared parallel backplane that links a host command stream to a set of identical compute nodes. Nodes sit in groups of six on boards, and every board slot carries a fixed address, so all boards and nodes can be loaded with the same configuration. The host issues one command at a time on a valid/ready port. Each command either writes a word to one node, to a chosen group of nodes on a board, or to every node on every board at once. It can also read a word back from a single node, or switch result collection on or off. No arbiter and no interrupt exist. The block therefore learns of finished work only by polling.

While polling is on and no host command waits, the controller steps through every node in a fixed round-robin order and reads its status word. It forwards that word to the host only when the node flags new data. Every bus transaction has the same shape: an address and select setup phase, a strobe phase, then release. The data bus is driven only while a write is in progress.

Top module: `bpbus_master`

## Requirements
- R1: The bus address is the 5-bit board number in bits [15:11] above the 11-bit register offset in bits [10:0]; board number 31 addresses every board at once.
- R2: A write asserts exactly the chip selects given in the command's node mask (bit i selects node i of the addressed boards), so one node, a group or all six can be written in one transaction.
- R3: After a command is accepted, address and chip selects appear in the next cycle and are held SETUP_CYC cycles with no strobe. A read or write strobe follows for STROBE_CYC cycles, and the chip selects then drop to zero for at least one cycle.
- R4: During a write strobe the bus data equals the command data and stays stable; the master drives the data bus only during write transactions.
- R5: A read of one node on a present board produces one read transaction and one response of kind 0 carrying the word sampled in the last strobe cycle, with that board and node index; rsp_valid is seen SETUP_CYC+STROBE_CYC+2 cycles after acceptance.
- R6: A command is rejected when its node mask is empty or its board is neither 31 nor below NUM_BOARDS. A read is also rejected when it names board 31 or more than one node. A rejected command causes no bus activity and yields a response of kind 2 in the cycle after acceptance.
- R7: Opcode 1 (start) writes the command data to register offset START_OFS of the targeted nodes and turns polling on; opcode 3 (stop) turns polling off with no bus activity and no response. Opcode 0 writes and opcode 2 reads at the command's offset.
- R8: Polling reads register offset STATUS_OFS of one node per transaction, with the node index rising fastest, then the board number, wrapping from the last node of board NUM_BOARDS-1 to board 0 node 0.
- R9: A polled status word is forwarded as a response of kind 1, with its board, node and full word, only when its bit 63 is set; otherwise nothing is sent to the host.
- R10: When a host command and a pending poll compete in an idle cycle, the host command is served first.
- R11: A response stays valid with unchanged contents until rsp_ready is high.
- R12: After reset the chip selects, strobes and rsp_valid are low, cmd_ready is high and polling is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 2 | 0 write, 1 start, 2 read, 3 stop |
| cmd_board | input | 5 | Target board, 31 for all boards |
| cmd_nodes | input | 6 | Node mask within the board |
| cmd_reg | input | 11 | Register offset on the node |
| cmd_data | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_kind | output | 2 | 0 read data, 1 poll result, 2 rejected |
| rsp_board | output | 5 | Board of the response |
| rsp_node | output | 3 | Node index of the response |
| rsp_data | output | 64 | Read or status word |
| bus_addr | output | 16 | Backplane address |
| bus_cs | output | 6 | Per-board node chip selects |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_data | inout | 64 | Shared data bus |

## Verification
The bench counts negedges from the first one after the command handshake. For a write, chip selects must show at counts 1 to SETUP_CYC and the strobe at the following STROBE_CYC counts, and the selects must be gone one count later. Read data must arrive at count SETUP_CYC+STROBE_CYC+2, and a rejection at count 1. Poll results have no fixed latency because they depend on the round-robin position, so the bench waits for them under a bound, checks their order through the sequence of observed strobes, and checks that host reads still complete while polling runs.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_START = 2'd1,
      OP_READ  = 2'd2,
      OP_STOP  = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      RSP_READ   = 2'd0,
      RSP_POLL   = 2'd1,
      RSP_REJECT = 2'd2
   } rsp_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BUS,
      ST_RSP
   } ctl_state_e;

   typedef enum logic [1:0] {
      TX_WRITE,
      TX_READ,
      TX_POLL
   } txn_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE
   } phase_e;
endpackage

// File: rtl/bbc_cmd_check.sv
module bbc_cmd_check import bbc_pkg::*; #(
   parameter int BOARD_W    = 5,
   parameter int NODES      = 6,
   parameter int NUM_BOARDS = 20
)(
   input  logic [1:0]         op,
   input  logic [BOARD_W-1:0] board,
   input  logic [NODES-1:0]   nodes,
   output logic               reject
);
   localparam logic [BOARD_W-1:0] ALL_BOARDS = '1;

   logic bad_board;
   logic bad_read;

   always_comb begin
      bad_board = (board != ALL_BOARDS) && (int'(board) >= NUM_BOARDS);
      bad_read  = (op_e'(op) == OP_READ) &&
                  ((board == ALL_BOARDS) || ($countones(nodes) != 1));
      reject    = (op_e'(op) != OP_STOP) &&
                  ((nodes == '0) || bad_board || bad_read);
   end
endmodule

// File: rtl/bbc_poll_ptr.sv
module bbc_poll_ptr #(
   parameter int BOARD_W    = 5,
   parameter int NODES      = 6,
   parameter int NUM_BOARDS = 20
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       advance,
   output logic [BOARD_W-1:0]         board,
   output logic [$clog2(NODES)-1:0]   node,
   output logic [NODES-1:0]           cs
);
   localparam int NODE_W = $clog2(NODES);
   localparam logic [NODE_W-1:0]  LAST_NODE  = NODE_W'(NODES - 1);
   localparam logic [BOARD_W-1:0] LAST_BOARD = BOARD_W'(NUM_BOARDS - 1);

   logic [BOARD_W-1:0] board_q;
   logic [NODE_W-1:0]  node_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         board_q <= '0;
         node_q  <= '0;
      end else if (advance) begin
         if (node_q == LAST_NODE) begin
            node_q  <= '0;
            board_q <= (board_q == LAST_BOARD) ? '0 : board_q + 1'b1;
         end else begin
            node_q <= node_q + 1'b1;
         end
      end
   end

   for (genvar i = 0; i < NODES; i++) begin : g_cs
      assign cs[i] = (node_q == NODE_W'(i));
   end

   assign board = board_q;
   assign node  = node_q;
endmodule

// File: rtl/bbc_bus_phy.sv
module bbc_bus_phy import bbc_pkg::*; #(
   parameter int DATA_W     = 64,
   parameter int ADDR_W     = 16,
   parameter int NODES      = 6,
   parameter int SETUP_CYC  = 1,
   parameter int STROBE_CYC = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_read,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NODES-1:0]  cs,
   input  logic [DATA_W-1:0] wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [NODES-1:0]  bus_cs,
   output logic              bus_rd,
   output logic              bus_wr,
   inout  wire  [DATA_W-1:0] bus_data
);
   localparam int CNT_W = $clog2(SETUP_CYC + STROBE_CYC + 1);
   localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);

   phase_e            ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              rd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [NODES-1:0]  cs_q;
   logic [DATA_W-1:0] wdata_q;
   logic              drive;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         cnt_q   <= '0;
         rd_q    <= 1'b0;
         addr_q  <= '0;
         cs_q    <= '0;
         wdata_q <= '0;
         done    <= 1'b0;
         rdata   <= '0;
      end else begin
         done <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q    <= PH_SETUP;
                  cnt_q   <= '0;
                  rd_q    <= is_read;
                  addr_q  <= addr;
                  cs_q    <= cs;
                  wdata_q <= wdata;
               end
            end
            PH_SETUP: begin
               if (cnt_q == SETUP_LAST) begin
                  ph_q  <= PH_STROBE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (cnt_q == STROBE_LAST) begin
                  ph_q <= PH_IDLE;
                  done <= 1'b1;
                  if (rd_q) rdata <= bus_data;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   always_comb begin
      bus_addr = (ph_q != PH_IDLE) ? addr_q : '0;
      bus_cs   = (ph_q != PH_IDLE) ? cs_q : '0;
      bus_rd   = (ph_q == PH_STROBE) && rd_q;
      bus_wr   = (ph_q == PH_STROBE) && !rd_q;
      drive    = (ph_q != PH_IDLE) && !rd_q;
   end

   assign bus_data = drive ? wdata_q : 'z;

   // R4
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && $past(bus_wr) |-> $stable(bus_data) && $stable(bus_addr));
endmodule

// File: rtl/bpbus_master.sv
module bpbus_master import bbc_pkg::*; #(
   parameter int DATA_W     = 64,
   parameter int ADDR_W     = 16,
   parameter int BOARD_W    = 5,
   parameter int NODES      = 6,
   parameter int NUM_BOARDS = 20,
   parameter int SETUP_CYC  = 1,
   parameter int STROBE_CYC = 2,
   parameter int STATUS_OFS = 0,
   parameter int START_OFS  = 1
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   output logic                       cmd_ready,
   input  logic [1:0]                 cmd_op,
   input  logic [BOARD_W-1:0]         cmd_board,
   input  logic [NODES-1:0]           cmd_nodes,
   input  logic [ADDR_W-BOARD_W-1:0]  cmd_reg,
   input  logic [DATA_W-1:0]          cmd_data,
   output logic                       rsp_valid,
   input  logic                       rsp_ready,
   output logic [1:0]                 rsp_kind,
   output logic [BOARD_W-1:0]         rsp_board,
   output logic [$clog2(NODES)-1:0]   rsp_node,
   output logic [DATA_W-1:0]          rsp_data,
   output logic [ADDR_W-1:0]          bus_addr,
   output logic [NODES-1:0]           bus_cs,
   output logic                       bus_rd,
   output logic                       bus_wr,
   inout  wire  [DATA_W-1:0]          bus_data
);
   localparam int REG_W    = ADDR_W - BOARD_W;
   localparam int NODE_W   = $clog2(NODES);
   localparam int FLAG_BIT = DATA_W - 1;

   if (NUM_BOARDS < 1 || NUM_BOARDS >= (1 << BOARD_W) - 1) begin : g_bad_boards
      $error("NUM_BOARDS must leave the all-boards code free");
   end
   if (SETUP_CYC < 1 || STROBE_CYC < 1) begin : g_bad_phase
      $error("each bus phase needs at least one cycle");
   end
   if (NODES < 2 || REG_W < 2) begin : g_bad_shape
      $error("address split leaves too few node or register bits");
   end

   function automatic logic [NODE_W-1:0] mask_to_idx(input logic [NODES-1:0] m);
      mask_to_idx = '0;
      for (int i = NODES - 1; i >= 0; i--) begin
         if (m[i]) mask_to_idx = NODE_W'(i);
      end
   endfunction

   ctl_state_e         state_q;
   txn_e               txn_q;
   rsp_e               kind_q;
   logic               poll_on_q;
   logic               accept;
   logic               reject;
   op_e                op;
   logic               phy_start;
   logic               phy_rd;
   logic [ADDR_W-1:0]  phy_addr;
   logic [NODES-1:0]   phy_cs;
   logic [DATA_W-1:0]  phy_wdata;
   logic               phy_done;
   logic [DATA_W-1:0]  phy_rdata;
   logic               poll_adv;
   logic [BOARD_W-1:0] poll_board;
   logic [NODE_W-1:0]  poll_node;
   logic [NODES-1:0]   poll_cs;

   bbc_cmd_check #(.BOARD_W(BOARD_W), .NODES(NODES), .NUM_BOARDS(NUM_BOARDS)) u_check (
      .op(cmd_op), .board(cmd_board), .nodes(cmd_nodes), .reject(reject));

   bbc_poll_ptr #(.BOARD_W(BOARD_W), .NODES(NODES), .NUM_BOARDS(NUM_BOARDS)) u_poll (
      .clk(clk), .rst_n(rst_n), .advance(poll_adv),
      .board(poll_board), .node(poll_node), .cs(poll_cs));

   bbc_bus_phy #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NODES(NODES),
                 .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC)) u_phy (
      .clk(clk), .rst_n(rst_n), .start(phy_start), .is_read(phy_rd),
      .addr(phy_addr), .cs(phy_cs), .wdata(phy_wdata),
      .done(phy_done), .rdata(phy_rdata),
      .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_data(bus_data));

   always_comb begin
      op        = op_e'(cmd_op);
      cmd_ready = (state_q == ST_IDLE);
      accept    = cmd_valid && cmd_ready;
      phy_start = 1'b0;
      poll_adv  = 1'b0;
      phy_rd    = (op == OP_READ);
      phy_cs    = cmd_nodes;
      phy_wdata = cmd_data;
      phy_addr  = {cmd_board, (op == OP_START) ? REG_W'(START_OFS) : cmd_reg};
      if (state_q == ST_IDLE) begin
         if (accept) begin
            phy_start = (op != OP_STOP) && !reject;
         end else if (poll_on_q) begin
            phy_start = 1'b1;
            poll_adv  = 1'b1;
            phy_rd    = 1'b1;
            phy_cs    = poll_cs;
            phy_addr  = {poll_board, REG_W'(STATUS_OFS)};
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         txn_q     <= TX_WRITE;
         kind_q    <= RSP_READ;
         poll_on_q <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_board <= '0;
         rsp_node  <= '0;
         rsp_data  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  rsp_board <= cmd_board;
                  rsp_node  <= mask_to_idx(cmd_nodes);
                  if (op == OP_STOP) begin
                     poll_on_q <= 1'b0;
                  end else if (reject) begin
                     rsp_valid <= 1'b1;
                     kind_q    <= RSP_REJECT;
                     rsp_data  <= '0;
                     state_q   <= ST_RSP;
                  end else begin
                     txn_q   <= (op == OP_READ) ? TX_READ : TX_WRITE;
                     state_q <= ST_BUS;
                     if (op == OP_START) poll_on_q <= 1'b1;
                  end
               end else if (poll_on_q) begin
                  txn_q     <= TX_POLL;
                  rsp_board <= poll_board;
                  rsp_node  <= poll_node;
                  state_q   <= ST_BUS;
               end
            end
            ST_BUS: begin
               if (phy_done) begin
                  if (txn_q == TX_WRITE ||
                      (txn_q == TX_POLL && !phy_rdata[FLAG_BIT])) begin
                     state_q <= ST_IDLE;
                  end else begin
                     rsp_valid <= 1'b1;
                     kind_q    <= (txn_q == TX_POLL) ? RSP_POLL : RSP_READ;
                     rsp_data  <= phy_rdata;
                     state_q   <= ST_RSP;
                  end
               end
            end
            default: begin
               if (rsp_ready) begin
                  rsp_valid <= 1'b0;
                  state_q   <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign rsp_kind = kind_q;

   // R3
   setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rd || bus_wr) |-> (bus_cs != '0) && (bus_cs == $past(bus_cs)));
   // R3
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_rd || bus_wr) |-> bus_cs == '0);
   // R5
   read_one_node_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> $countones(bus_cs) == 1);
   // R6
   reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_kind == RSP_REJECT |-> bus_cs == '0);
   // R9
   poll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_kind == RSP_POLL |-> rsp_data[FLAG_BIT]);
   // R11
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_kind));
endmodule

// File: tb/bpbus_master_tb.sv
module bpbus_master_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NB  = 4;
   localparam int ND  = 6;
   localparam int S   = 2;
   localparam int T   = 3;
   localparam int STATUS_OFS = 0;
   localparam int START_OFS  = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = '0;
   logic [4:0]  cmd_board = '0;
   logic [5:0]  cmd_nodes = '0;
   logic [10:0] cmd_reg = '0;
   logic [63:0] cmd_data = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [1:0]  rsp_kind;
   logic [4:0]  rsp_board;
   logic [2:0]  rsp_node;
   logic [63:0] rsp_data;
   logic [15:0] bus_addr;
   logic [5:0]  bus_cs;
   logic        bus_rd;
   logic        bus_wr;
   wire  [63:0] bus_data;

   int checks = 0;
   int errors = 0;

   logic [63:0] status [NB][ND];
   logic        slv_en;
   logic [63:0] slv_val;

   always #(CLK_PERIOD/2) clk = ~clk;

   bpbus_master #(.NUM_BOARDS(NB), .SETUP_CYC(S), .STROBE_CYC(T),
                  .STATUS_OFS(STATUS_OFS), .START_OFS(START_OFS)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_board(cmd_board), .cmd_nodes(cmd_nodes),
      .cmd_reg(cmd_reg), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_board(rsp_board),
      .rsp_node(rsp_node), .rsp_data(rsp_data), .bus_addr(bus_addr),
      .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_data(bus_data));

   function automatic logic [63:0] node_word(input int b, input int n, input logic [10:0] r);
      node_word = {8'(b), 8'(n), 5'b0, r, 32'h5A5A_0000 | 32'(b * 7 + n)};
   endfunction

   function automatic int cs_idx(input logic [5:0] m);
      cs_idx = 0;
      for (int i = ND - 1; i >= 0; i--) if (m[i]) cs_idx = i;
   endfunction

   // bench model of the node slaves
   always_comb begin
      slv_en  = 1'b0;
      slv_val = '0;
      if (bus_rd && $countones(bus_cs) == 1 && int'(bus_addr[15:11]) < NB) begin
         slv_en = 1'b1;
         if (bus_addr[10:0] == 11'(STATUS_OFS))
            slv_val = status[int'(bus_addr[15:11])][cs_idx(bus_cs)];
         else
            slv_val = node_word(int'(bus_addr[15:11]), cs_idx(bus_cs), bus_addr[10:0]);
      end
   end
   assign bus_data = slv_en ? slv_val : 'z;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // drive a command at a negedge and return at the first negedge after the handshake
   task automatic send(input logic [1:0] op, input logic [4:0] b, input logic [5:0] m,
                       input logic [10:0] r, input logic [63:0] d);
      bit hs;
      cmd_op = op; cmd_board = b; cmd_nodes = m; cmd_reg = r; cmd_data = d;
      cmd_valid = 1'b1;
      do begin
         hs = cmd_ready;
         @(negedge clk);
      end while (!hs);
      cmd_valid = 1'b0;
   endtask

   task automatic do_write(input logic [1:0] op, input logic [4:0] b, input logic [5:0] m,
                           input logic [10:0] r, input logic [63:0] d);
      int bad_addr = 0, bad_cs = 0, bad_data = 0, bad_time = 0;
      logic [15:0] exp_addr;
      exp_addr = {b, (op == 2'd1) ? 11'(START_OFS) : r};
      send(op, b, m, r, d);
      for (int k = 1; k <= S + T + 1; k++) begin
         if (k <= S + T) begin
            if (bus_addr != exp_addr) bad_addr++;
            if (bus_cs != m) bad_cs++;
            if (bus_rd) bad_time++;
            if (k <= S && bus_wr) bad_time++;
            if (k > S && !bus_wr) bad_time++;
            if (k > S && bus_data != d) bad_data++;
         end else begin
            if (bus_cs != '0 || bus_wr) bad_time++;
         end
         @(negedge clk);
      end
      chk(bad_addr == 0, "R1 write address", 64'(bus_addr), 64'(exp_addr));
      chk(bad_cs == 0, "R2 write chip selects", 64'(bad_cs), 64'(0));
      chk(bad_time == 0, "R3 write phase timing", 64'(bad_time), 64'(0));
      chk(bad_data == 0, "R4 write data on bus", 64'(bad_data), 64'(0));
   endtask

   task automatic do_read(input logic [4:0] b, input logic [5:0] m, input logic [10:0] r,
                          input int exp_lat, input bit hold);
      int k = 0;
      logic [63:0] exp;
      exp = node_word(int'(b), cs_idx(m), r);
      if (hold) rsp_ready = 1'b0;
      send(2'd2, b, m, r, 64'(0));
      k = 1;
      while (!rsp_valid && k < 200) begin
         @(negedge clk);
         k++;
      end
      if (exp_lat > 0) chk(k == exp_lat, "R5 read latency", 64'(k), 64'(exp_lat));
      else chk(k < 200, "R10 host read served while polling", 64'(k), 64'(0));
      chk(rsp_kind == 2'd0, "R5 read response kind", 64'(rsp_kind), 64'(0));
      chk(rsp_data == exp && rsp_board == b && int'(rsp_node) == cs_idx(m),
          "R5 read data and origin", rsp_data, exp);
      if (hold) begin
         repeat (3) @(negedge clk);
         chk(rsp_valid && rsp_data == exp, "R11 response held", rsp_data, exp);
         rsp_ready = 1'b1;
         @(negedge clk);
         chk(!rsp_valid, "R11 response released after ready", 64'(rsp_valid), 64'(0));
      end else begin
         @(negedge clk);
      end
   endtask

   task automatic do_reject(input logic [1:0] op, input logic [4:0] b, input logic [5:0] m);
      send(op, b, m, 11'h10, 64'hFFFF);
      chk(rsp_valid && rsp_kind == 2'd2, "R6 reject response", 64'(rsp_kind), 64'(2));
      chk(bus_cs == '0 && !bus_rd && !bus_wr, "R6 no bus activity", 64'(bus_cs), 64'(0));
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4711);
      for (int b = 0; b < NB; b++)
         for (int n = 0; n < ND; n++) status[b][n] = 64'(b * 16 + n);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_cs == '0 && !bus_rd && !bus_wr && !rsp_valid && cmd_ready,
          "R12 reset state", 64'({bus_cs, bus_rd, bus_wr, rsp_valid}), 64'(0));

      // directed writes: one node, a group, every node everywhere
      do_write(2'd0, 5'd1, 6'b000100, 11'h123, 64'hDEAD_BEEF_0123_4567);
      do_write(2'd0, 5'd3, 6'b101001, 11'h7FE, 64'h0F0F_F0F0_1111_2222);
      do_write(2'd0, 5'd31, 6'b111111, 11'h040, 64'hAAAA_5555_AAAA_5555);

      for (int i = 0; i < 16; i++) begin
         logic [4:0] b;
         logic [5:0] m;
         b = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % NB);
         m = 6'($urandom % 63 + 1);
         do_write(2'd0, b, m, 11'($urandom), {$urandom, $urandom});
      end

      do_read(5'd2, 6'b010000, 11'h055, S + T + 2, 1'b0);
      do_read(5'd0, 6'b000001, 11'h7FF, S + T + 2, 1'b1);
      for (int i = 0; i < 8; i++) begin
         do_read(5'($urandom % NB), 6'(1 << ($urandom % ND)), 11'($urandom % 2047 + 1),
                 S + T + 2, 1'b0);
      end

      do_reject(2'd2, 5'd31, 6'b000001);
      do_reject(2'd2, 5'd1, 6'b000011);
      do_reject(2'd0, 5'd2, 6'b000000);
      do_reject(2'd0, 5'(NB), 6'b000001);

      // start: broadcast to the start register and turn polling on
      do_write(2'd1, 5'd31, 6'b111111, 11'h000, 64'h0000_0000_0000_0001);
      begin
         int bad_order = 0, stray = 0, seen = 0;
         int eb = 0, en = 0;
         bit prev_rd = 1'b0;
         while (seen < 2 * NB * ND) begin
            if (bus_rd && !prev_rd) begin
               if (int'(bus_addr[15:11]) != eb || cs_idx(bus_cs) != en ||
                   bus_addr[10:0] != 11'(STATUS_OFS)) bad_order++;
               seen++;
               en++;
               if (en == ND) begin
                  en = 0;
                  eb = (eb == NB - 1) ? 0 : eb + 1;
               end
            end
            if (rsp_valid) stray++;
            prev_rd = bus_rd;
            @(negedge clk);
         end
         chk(bad_order == 0, "R8 poll round-robin order", 64'(bad_order), 64'(0));
         chk(stray == 0, "R9 no forward without flag", 64'(stray), 64'(0));
      end

      status[2][4] = 64'h8000_0000_CAFE_0042;
      begin
         int k = 0;
         while (!rsp_valid && k < 2000) begin
            @(negedge clk);
            k++;
         end
         chk(rsp_kind == 2'd1 && rsp_board == 5'd2 && rsp_node == 3'd4,
             "R9 poll result origin", 64'({rsp_kind, rsp_board, rsp_node}),
             64'({2'd1, 5'd2, 3'd4}));
         chk(rsp_data == 64'h8000_0000_CAFE_0042, "R9 poll result word",
             rsp_data, 64'h8000_0000_CAFE_0042);
         status[2][4] = 64'h0000_0000_CAFE_0042;
         @(negedge clk);
      end

      do_read(5'd1, 6'b001000, 11'h0A0, 0, 1'b0);

      // stop: polling must cease
      send(2'd3, 5'd0, 6'b000001, 11'h0, 64'h0);
      begin
         int reads = 0;
         repeat (60) begin
            if (bus_rd) reads++;
            @(negedge clk);
         end
         chk(reads == 0 && !rsp_valid, "R7 stop halts polling", 64'(reads), 64'(0));
      end

      do_read(5'd3, 6'b100000, 11'h321, S + T + 2, 1'b0);
      summary();
   end
endmodule